// File: doc/BRIEF.md
# Multiplexed-Bus Peripheral Register Front End

This block is the host-facing front end of a peripheral that combines a 256-byte RAM, parallel I/O ports and an interval timer behind a multiplexed 8-bit address/data bus. The host puts an address on the shared bus with the latch strobe high. On the strobe's falling edge the block captures that address together with the chip-enable level and the memory/IO select. The following read or write strobe is then steered either to the RAM or to one of eight I/O register slots, picked by the low three address bits.

Inside the block are the write-only command byte, the assembled read-only status byte, and the data latches of the two 8-bit ports with their direction rules. A port in input mode holds its latch at zero and ignores writes, so a port switched to output always starts driving zeros. The third port's handshake logic and the timer core are separate neighbour blocks. They receive one-cycle write strobes and the captured write data, and they return their read values and status bits. Tri-state drive of the shared bus appears as a separate data output and output enable.

All bus inputs are sampled on the block clock. A strobe edge is detected one clock after the pin moves. Register writes and neighbour strobes take effect on that same edge.

Top module: `mbp_if`

## Requirements
- R1: The block latches the address, the chip-enable level and the memory/IO select at the clock that sees the latch strobe go from high to low. Later changes on the bus during that access do not change which location is accessed.
- R2: With the captured memory/IO select low, a write stores the bus byte into the RAM location given by all 8 captured address bits, and a read returns it. All 256 locations are independent.
- R3: With the captured memory/IO select high, only captured address bits 2:0 pick the register (0 command/status, 1 port A, 2 port B, 3 port C, 4 timer low, 5 timer high); bits 7:3 have no effect.
- R4: A write to I/O slot 0 loads the command byte (bit 0 port A direction, bit 1 port B direction, 1 = output) and pulses `cmd_wr_o`. A read of slot 0 returns {0, `tmr_irq_i`, `hs_stat_i[5:0]`} and never the command byte. `cmd_o` changes only on a command write.
- R5: The chip-enable polarity is set by parameter `CE_ACT_HIGH` (default 0, active low). An access whose captured chip enable is inactive writes nothing, pulses nothing and leaves the bus released.
- R6: Reset clears the command byte, so all ports are in input mode, and clears both port output latches. The bus is released and no strobe is active.
- R7: A read of a port's slot returns its output latch while the port is an output and its pins (`pa_i`/`pb_i`) while it is an input. A read of slot 3 returns {00, `pc_rd_i`}, and slots 4 and 5 return `tmr_lo_i` and `tmr_hi_i`.
- R8: While a port is in input mode its output latch reads zero on its pin outputs from the second clock on, and writes to it are ignored. After a switch to output the pins drive zero until the port is written.
- R9: `ad_oe_o` is high only while `rd_ni` is low and the captured chip enable is active. `ad_o` is zero whenever `ad_oe_o` is low.
- R10: I/O slots 6 and 7 read as zero with the bus driven. Writes to them change no register and pulse no strobe.
- R11: A write to slot 3, 4 or 5 gives a one-cycle pulse on `pc_wr_o`, `tmr_wr_lo_o` or `tmr_wr_hi_o` with the written byte on `wdata_o`. A read of slot 0 gives a one-cycle pulse on `stat_rd_o`. At most one of these strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch strobe, captured on its falling edge |
| ce_i | input | 1 | Chip enable, polarity set by CE_ACT_HIGH |
| io_sel_i | input | 1 | 0 selects RAM, 1 selects I/O registers |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared bus, input side |
| ad_o | output | 8 | Shared bus, driven read data |
| ad_oe_o | output | 1 | Bus output enable |
| pa_i | input | 8 | Port A pin levels |
| pa_o | output | 8 | Port A output latch |
| pa_oe_o | output | 1 | Port A is an output |
| pb_i | input | 8 | Port B pin levels |
| pb_o | output | 8 | Port B output latch |
| pb_oe_o | output | 1 | Port B is an output |
| cmd_o | output | 8 | Command byte to neighbour blocks |
| cmd_wr_o | output | 1 | One-cycle pulse on command write |
| hs_stat_i | input | 6 | Port handshake status bits |
| tmr_irq_i | input | 1 | Timer terminal-count flag |
| stat_rd_o | output | 1 | One-cycle pulse on status read |
| pc_rd_i | input | 6 | Port C read value |
| pc_wr_o | output | 1 | One-cycle pulse on port C write |
| tmr_lo_i | input | 8 | Timer low byte read value |
| tmr_hi_i | input | 8 | Timer high byte read value |
| tmr_wr_lo_o | output | 1 | One-cycle pulse on timer low write |
| tmr_wr_hi_o | output | 1 | One-cycle pulse on timer high write |
| wdata_o | output | 8 | Byte of the last write, valid with the pulses |

## Verification
A wrong captured address or select shows up on the next read as the byte of another RAM cell or register. A wrong command byte appears one clock after the write as a wrong direction on `pa_oe_o`/`pb_oe_o`, or on `cmd_o` itself. A port latch that survives input mode or accepts a write there shows on `pa_o`/`pb_o` within two clocks, and again on the next read of the port after a switch to output. Stray or doubled strobe pulses are counted at the ports as they occur. Random accesses are mixed with directed cases for the chip-enable polarity, the reserved slots and the address bits above bit 2.

// File: rtl/mbp_pkg.sv
package mbp_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 8;
  localparam int unsigned SEL_W = 3;
  localparam int unsigned PC_W  = 6;
  localparam int unsigned NPORT = 2;

  typedef enum logic [SEL_W-1:0] {
    SLOT_CS   = 3'd0,
    SLOT_PA   = 3'd1,
    SLOT_PB   = 3'd2,
    SLOT_PC   = 3'd3,
    SLOT_TLO  = 3'd4,
    SLOT_THI  = 3'd5,
    SLOT_RSV6 = 3'd6,
    SLOT_RSV7 = 3'd7
  } slot_e;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          io;
    logic          ce_ok;
  } acc_t;
endpackage

// File: rtl/mbp_capture.sv
module mbp_capture
  import mbp_pkg::*;
#(
  parameter bit CE_ACT_HIGH = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic          ce_i,
  input  logic          io_sel_i,
  input  logic          rd_ni,
  input  logic          wr_ni,
  input  logic [AW-1:0] ad_i,
  output acc_t          acc_o,
  output logic          wr_go_o,
  output logic          rd_go_o,
  output logic          rd_act_o
);
  logic ale_q, rd_q, wr_q;
  acc_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ale_q <= 1'b0;
      rd_q  <= 1'b1;
      wr_q  <= 1'b1;
      acc_q <= '0;
    end else begin
      ale_q <= ale_i;
      rd_q  <= rd_ni;
      wr_q  <= wr_ni;
      if (ale_q && !ale_i) begin
        acc_q.addr  <= ad_i;
        acc_q.io    <= io_sel_i;
        acc_q.ce_ok <= (ce_i == CE_ACT_HIGH);
      end
    end
  end

  assign acc_o    = acc_q;
  assign wr_go_o  = wr_q & ~wr_ni & acc_q.ce_ok;
  assign rd_go_o  = rd_q & ~rd_ni & acc_q.ce_ok;
  assign rd_act_o = ~rd_ni & acc_q.ce_ok;
endmodule

// File: rtl/mbp_ram.sv
module mbp_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[addr_i] <= wdata_i;
  end

  assign rdata_o = mem[addr_i];
endmodule

// File: rtl/mbp_regs.sv
module mbp_regs
  import mbp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  acc_t                     acc_i,
  input  logic                     wr_go_i,
  input  logic                     rd_go_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            cmd_o,
  output logic [NPORT-1:0][DW-1:0] lat_o,
  output logic [NPORT-1:0]         dir_o,
  output logic                     cmd_wr_o,
  output logic                     stat_rd_o,
  output logic                     pc_wr_o,
  output logic                     tmr_wr_lo_o,
  output logic                     tmr_wr_hi_o,
  output logic [DW-1:0]            wdata_o
);
  slot_e slot;
  logic  io_wr, io_rd;

  assign slot  = slot_e'(acc_i.addr[SEL_W-1:0]);
  assign io_wr = wr_go_i & acc_i.io;
  assign io_rd = rd_go_i & acc_i.io;

  logic [DW-1:0] cmd_q, wd_q;
  logic cmd_p, stat_p, pc_p, tlo_p, thi_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      wd_q   <= '0;
      cmd_p  <= 1'b0;
      stat_p <= 1'b0;
      pc_p   <= 1'b0;
      tlo_p  <= 1'b0;
      thi_p  <= 1'b0;
    end else begin
      cmd_p  <= io_wr && slot == SLOT_CS;
      stat_p <= io_rd && slot == SLOT_CS;
      pc_p   <= io_wr && slot == SLOT_PC;
      tlo_p  <= io_wr && slot == SLOT_TLO;
      thi_p  <= io_wr && slot == SLOT_THI;
      if (io_wr) wd_q <= wdata_i;
      if (io_wr && slot == SLOT_CS) cmd_q <= wdata_i;
    end
  end

  // port latches: cleared and write-locked while the port is an input
  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam slot_e MY_SLOT = (g == 0) ? SLOT_PA : SLOT_PB;
    logic [DW-1:0] lat_q;
    logic          dir;
    assign dir = cmd_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        lat_q <= '0;
      else if (!dir)                      lat_q <= '0;
      else if (io_wr && slot == MY_SLOT)  lat_q <= wdata_i;
    end

    assign lat_o[g] = lat_q;
    assign dir_o[g] = dir;
  end

  assign cmd_o       = cmd_q;
  assign cmd_wr_o    = cmd_p;
  assign stat_rd_o   = stat_p;
  assign pc_wr_o     = pc_p;
  assign tmr_wr_lo_o = tlo_p;
  assign tmr_wr_hi_o = thi_p;
  assign wdata_o     = wd_q;
endmodule

// File: rtl/mbp_if.sv
module mbp_if
  import mbp_pkg::*;
#(
  parameter bit CE_ACT_HIGH = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic            ce_i,
  input  logic            io_sel_i,
  input  logic            rd_ni,
  input  logic            wr_ni,
  input  logic [DW-1:0]   ad_i,
  output logic [DW-1:0]   ad_o,
  output logic            ad_oe_o,
  input  logic [DW-1:0]   pa_i,
  output logic [DW-1:0]   pa_o,
  output logic            pa_oe_o,
  input  logic [DW-1:0]   pb_i,
  output logic [DW-1:0]   pb_o,
  output logic            pb_oe_o,
  output logic [DW-1:0]   cmd_o,
  output logic            cmd_wr_o,
  input  logic [PC_W-1:0] hs_stat_i,
  input  logic            tmr_irq_i,
  output logic            stat_rd_o,
  input  logic [PC_W-1:0] pc_rd_i,
  output logic            pc_wr_o,
  input  logic [DW-1:0]   tmr_lo_i,
  input  logic [DW-1:0]   tmr_hi_i,
  output logic            tmr_wr_lo_o,
  output logic            tmr_wr_hi_o,
  output logic [DW-1:0]   wdata_o
);
  localparam int unsigned STAT_PAD = DW - PC_W - 1;
  localparam int unsigned PC_PAD   = DW - PC_W;

  acc_t acc;
  logic wr_go, rd_go, rd_act, ce_ok;
  logic [DW-1:0] ram_rd, rd_data;
  logic [NPORT-1:0][DW-1:0] lat;
  logic [NPORT-1:0] dir;

  mbp_capture #(.CE_ACT_HIGH(CE_ACT_HIGH)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ale_i   (ale_i),
    .ce_i    (ce_i),
    .io_sel_i(io_sel_i),
    .rd_ni   (rd_ni),
    .wr_ni   (wr_ni),
    .ad_i    (ad_i),
    .acc_o   (acc),
    .wr_go_o (wr_go),
    .rd_go_o (rd_go),
    .rd_act_o(rd_act)
  );

  assign ce_ok = acc.ce_ok;

  mbp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (wr_go & ~acc.io),
    .addr_i (acc.addr),
    .wdata_i(ad_i),
    .rdata_o(ram_rd)
  );

  mbp_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .acc_i      (acc),
    .wr_go_i    (wr_go),
    .rd_go_i    (rd_go),
    .wdata_i    (ad_i),
    .cmd_o      (cmd_o),
    .lat_o      (lat),
    .dir_o      (dir),
    .cmd_wr_o   (cmd_wr_o),
    .stat_rd_o  (stat_rd_o),
    .pc_wr_o    (pc_wr_o),
    .tmr_wr_lo_o(tmr_wr_lo_o),
    .tmr_wr_hi_o(tmr_wr_hi_o),
    .wdata_o    (wdata_o)
  );

  always_comb begin
    rd_data = '0;
    if (!acc.io) begin
      rd_data = ram_rd;
    end else begin
      unique case (slot_e'(acc.addr[SEL_W-1:0]))
        SLOT_CS:  rd_data = {{STAT_PAD{1'b0}}, tmr_irq_i, hs_stat_i};
        SLOT_PA:  rd_data = dir[0] ? lat[0] : pa_i;
        SLOT_PB:  rd_data = dir[1] ? lat[1] : pb_i;
        SLOT_PC:  rd_data = {{PC_PAD{1'b0}}, pc_rd_i};
        SLOT_TLO: rd_data = tmr_lo_i;
        SLOT_THI: rd_data = tmr_hi_i;
        default:  rd_data = '0;
      endcase
    end
  end

  assign ad_oe_o = rd_act;
  assign ad_o    = rd_act ? rd_data : '0;
  assign pa_o    = lat[0];
  assign pb_o    = lat[1];
  assign pa_oe_o = dir[0];
  assign pb_oe_o = dir[1];
endmodule

// File: rtl/mbp_if_chk.sv
module mbp_if_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       rd_ni,
  input logic       ad_oe_o,
  input logic [7:0] ad_o,
  input logic       ce_ok_i,
  input logic [7:0] pa_o,
  input logic       pa_oe_o,
  input logic [7:0] pb_o,
  input logic       pb_oe_o,
  input logic [7:0] cmd_o,
  input logic       cmd_wr_o,
  input logic       stat_rd_o,
  input logic       pc_wr_o,
  input logic       tmr_wr_lo_o,
  input logic       tmr_wr_hi_o
);
  p_oe_needs_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !rd_ni);

  p_bus_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ad_oe_o |-> ad_o == 8'h00);

  p_oe_needs_ce_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> ce_ok_i);

  p_pa_input_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pa_oe_o && $past(!pa_oe_o)) |-> pa_o == 8'h00);

  p_pb_input_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pb_oe_o && $past(!pb_oe_o)) |-> pb_o == 8'h00);

  p_cmd_only_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> cmd_wr_o);

  p_strobe_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_wr_o, stat_rd_o, pc_wr_o, tmr_wr_lo_o, tmr_wr_hi_o}));

  p_cmd_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr_o |=> !cmd_wr_o);

  p_pc_pulse_single_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |=> !pc_wr_o);
endmodule

bind mbp_if mbp_if_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_ni      (rd_ni),
  .ad_oe_o    (ad_oe_o),
  .ad_o       (ad_o),
  .ce_ok_i    (ce_ok),
  .pa_o       (pa_o),
  .pa_oe_o    (pa_oe_o),
  .pb_o       (pb_o),
  .pb_oe_o    (pb_oe_o),
  .cmd_o      (cmd_o),
  .cmd_wr_o   (cmd_wr_o),
  .stat_rd_o  (stat_rd_o),
  .pc_wr_o    (pc_wr_o),
  .tmr_wr_lo_o(tmr_wr_lo_o),
  .tmr_wr_hi_o(tmr_wr_hi_o)
);

// File: tb/tb_mbp_if.sv
module tb_mbp_if;
  localparam int CLK_PERIOD = 10;
  localparam bit CE_HI = 1'b0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       ale = 0, ce = ~CE_HI, io = 0, rd_n = 1, wr_n = 1;
  logic [7:0] ad = 0, pa_pin = 0, pb_pin = 0, tlo = 0, thi = 0;
  logic [5:0] hs = 0, pc_rd = 0;
  logic       irq = 0;
  logic [7:0] ad_o, pa_o, pb_o, cmd_o, wdata_o;
  logic       ad_oe, pa_oe, pb_oe, cmd_wr, stat_rd, pc_wr, twl, twh;

  mbp_if #(.CE_ACT_HIGH(CE_HI)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .ce_i(ce), .io_sel_i(io),
    .rd_ni(rd_n), .wr_ni(wr_n), .ad_i(ad), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .pa_i(pa_pin), .pa_o(pa_o), .pa_oe_o(pa_oe),
    .pb_i(pb_pin), .pb_o(pb_o), .pb_oe_o(pb_oe),
    .cmd_o(cmd_o), .cmd_wr_o(cmd_wr), .hs_stat_i(hs), .tmr_irq_i(irq),
    .stat_rd_o(stat_rd), .pc_rd_i(pc_rd), .pc_wr_o(pc_wr),
    .tmr_lo_i(tlo), .tmr_hi_i(thi), .tmr_wr_lo_o(twl), .tmr_wr_hi_o(twh),
    .wdata_o(wdata_o)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int n_cmd = 0, n_stat = 0, n_pc = 0, n_tlo = 0, n_thi = 0;
  logic [7:0] last_wd = 0;

  // model
  logic [7:0] m_ram [256];
  logic [7:0] m_cmd = 0, m_pa = 0, m_pb = 0;

  always @(negedge clk) begin
    if (cmd_wr) n_cmd++;
    if (stat_rd) n_stat++;
    if (pc_wr) begin n_pc++; last_wd = wdata_o; end
    if (twl) begin n_tlo++; last_wd = wdata_o; end
    if (twh) begin n_thi++; last_wd = wdata_o; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic act_ce(input bit on);
    return on ? CE_HI : ~CE_HI;
  endfunction

  function automatic logic [7:0] exp_io(input logic [2:0] s);
    case (s)
      3'd0: return {1'b0, irq, hs};
      3'd1: return m_cmd[0] ? m_pa : pa_pin;
      3'd2: return m_cmd[1] ? m_pb : pb_pin;
      3'd3: return {2'b00, pc_rd};
      3'd4: return tlo;
      3'd5: return thi;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input bit isio, input logic [7:0] a, input logic [7:0] d, input bit on);
    if (!on) return;
    if (!isio) m_ram[a] = d;
    else case (a[2:0])
      3'd0: m_cmd = d;
      3'd1: if (m_cmd[0]) m_pa = d;
      3'd2: if (m_cmd[1]) m_pb = d;
      default: ;
    endcase
    if (!m_cmd[0]) m_pa = 0;
    if (!m_cmd[1]) m_pb = 0;
  endtask

  task automatic bus_wr(input bit isio, input logic [7:0] a, input logic [7:0] d, input bit on);
    @(negedge clk); ad = a; io = isio; ce = act_ce(on); ale = 1;
    @(negedge clk); ale = 0;
    @(negedge clk); ad = d; wr_n = 0;
    @(negedge clk); wr_n = 1; ad = $urandom;
    @(negedge clk);
    @(negedge clk);
    model_wr(isio, a, d, on);
  endtask

  task automatic bus_rd(input bit isio, input logic [7:0] a, input bit on,
                        output logic [7:0] d, output logic oe);
    @(negedge clk); ad = a; io = isio; ce = act_ce(on); ale = 1;
    @(negedge clk); ale = 0;
    @(negedge clk); ad = $urandom; rd_n = 0;
    @(negedge clk); d = ad_o; oe = ad_oe;
    rd_n = 1;
    @(negedge clk);
    chk(ad_oe == 0, "R9 oe release", ad_oe, 0);
  endtask

  task automatic chk_ports(input string tag);
    chk(pa_o == m_pa && pa_oe == m_cmd[0], {tag, " pa"}, {pa_oe, pa_o}, {m_cmd[0], m_pa});
    chk(pb_o == m_pb && pb_oe == m_cmd[1], {tag, " pb"}, {pb_oe, pb_o}, {m_cmd[1], m_pb});
    chk(cmd_o == m_cmd, {tag, " cmd"}, cmd_o, m_cmd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    int c0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(cmd_o == 0 && pa_o == 0 && pb_o == 0 && !pa_oe && !pb_oe, "R6 reset regs",
        {cmd_o, pa_o, pb_o}, 0);
    chk(!ad_oe && ad_o == 0, "R6 bus released", ad_oe, 0);
    chk(!cmd_wr && !pc_wr && !twl && !twh && !stat_rd, "R6 strobes", {cmd_wr, pc_wr}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2/R1: fill RAM (data changes the bus after the latch) and read back
    for (int i = 0; i < 256; i++) bus_wr(0, 8'(i), 8'(i * 37 + 11), 1);
    for (int i = 0; i < 256; i += 17) begin
      bus_rd(0, 8'(i), 1, d, oe);
      chk(oe && d == m_ram[i], "R2 R1 ram readback", d, m_ram[i]);
    end

    // R5 inactive chip enable
    bus_wr(0, 8'h10, 8'hEE, 0);
    bus_rd(0, 8'h10, 1, d, oe);
    chk(d == m_ram[16], "R5 ce off write ignored", d, m_ram[16]);
    bus_rd(0, 8'h10, 0, d, oe);
    chk(!oe && d == 0, "R5 ce off read released", {oe, d}, 0);
    c0 = n_cmd;
    bus_wr(1, 8'h00, 8'h03, 0);
    chk(cmd_o == 0 && n_cmd == c0, "R5 ce off no cmd", cmd_o, 0);

    // R8 input mode ignores writes
    pa_pin = 8'hA5;
    bus_wr(1, 8'h01, 8'h77, 1);
    chk(pa_o == 0, "R8 input write ignored", pa_o, 0);
    bus_rd(1, 8'h01, 1, d, oe);
    chk(d == 8'hA5, "R7 input reads pins", d, 8'hA5);
    // switch to output: pins start at zero
    bus_wr(1, 8'h00, 8'h03, 1);
    chk(pa_oe && pa_o == 0 && pb_oe && pb_o == 0, "R8 switch to output zero", pa_o, 0);
    chk(n_cmd == c0 + 1, "R4 cmd pulse", n_cmd, c0 + 1);
    // R3 upper bits ignored
    bus_wr(1, 8'hA9, 8'h5C, 1);
    chk(pa_o == 8'h5C, "R3 upper bits ignored", pa_o, 8'h5C);
    bus_wr(1, 8'hF2, 8'hC3, 1);
    chk(pb_o == 8'hC3, "R3 port b alias", pb_o, 8'hC3);
    bus_rd(1, 8'h39, 1, d, oe);
    chk(d == 8'h5C, "R7 output reads latch", d, 8'h5C);
    // back to input clears latch
    bus_wr(1, 8'h08, 8'h02, 1);
    chk(pa_o == 0 && !pa_oe && pb_o == 8'hC3, "R8 input clears latch", pa_o, 0);

    // R4 status read, never command
    hs = 6'h2A; irq = 1;
    c0 = n_stat;
    bus_rd(1, 8'h00, 1, d, oe);
    chk(oe && d == 8'h6A, "R4 status byte", d, 8'h6A);
    chk(n_stat == c0 + 1, "R11 stat pulse", n_stat, c0 + 1);

    // R11 neighbour strobes
    c0 = n_pc;
    bus_wr(1, 8'h03, 8'h9D, 1);
    chk(n_pc == c0 + 1 && last_wd == 8'h9D, "R11 pc pulse", last_wd, 8'h9D);
    c0 = n_tlo;
    bus_wr(1, 8'h04, 8'h12, 1);
    chk(n_tlo == c0 + 1 && last_wd == 8'h12, "R11 tmr lo pulse", last_wd, 8'h12);
    c0 = n_thi;
    bus_wr(1, 8'h05, 8'hC7, 1);
    chk(n_thi == c0 + 1 && last_wd == 8'hC7, "R11 tmr hi pulse", last_wd, 8'hC7);

    // R10 reserved slots
    c0 = n_cmd + n_pc + n_tlo + n_thi;
    bus_wr(1, 8'h06, 8'hFF, 1);
    bus_wr(1, 8'hFF, 8'hFF, 1);
    chk(n_cmd + n_pc + n_tlo + n_thi == c0, "R10 no strobes", n_cmd + n_pc + n_tlo + n_thi, c0);
    chk_ports("R10 regs unchanged");
    bus_rd(1, 8'h07, 1, d, oe);
    chk(oe && d == 0, "R10 reads zero", {oe, d}, 9'h100);

    // random mix
    for (int k = 0; k < 500; k++) begin
      bit isio = $urandom_range(0, 1);
      bit on = ($urandom_range(0, 7) != 0);
      logic [7:0] a = $urandom;
      logic [7:0] v = $urandom;
      pa_pin = $urandom; pb_pin = $urandom; pc_rd = $urandom;
      tlo = $urandom; thi = $urandom; hs = $urandom; irq = $urandom;
      if (isio && a[2:0] == 0 && $urandom_range(0, 1)) v[7:2] = 0;
      if ($urandom_range(0, 1)) begin
        bus_wr(isio, a, v, on);
        chk_ports("R7 R8 random ports");
      end else begin
        logic [7:0] e;
        e = isio ? exp_io(a[2:0]) : m_ram[a];
        bus_rd(isio, a, on, d, oe);
        if (on) chk(oe && d == e, "R2 R3 R7 random read", d, e);
        else    chk(!oe && d == 0, "R5 random ce off", {oe, d}, 0);
      end
    end

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule